// File: doc/BRIEF.md
# Multi-Channel Level Interrupt Multiplexer

This block collects one shared set of active-high, level-sensitive interrupt source lines and fans them out to several independent channels. Each channel holds its own enable mask and raises its own interrupt output whenever any source that the mask lets through is high. A channel's output therefore follows the sources it is allowed to see, and a single interrupt controller input can serve a whole group of peripherals.

Software reaches each channel through a simple register bus with an address, a write strobe, write data and combinational read data. Each channel has two registers, spaced at a fixed per-channel stride. The enable register can be read and written, so its contents can be saved and later written back. The pending register is read-only and shows which enabled sources are high at that moment. Every access is a single-cycle, word-aligned transfer.

Top module: `irq_fanin_mux`

## Requirements
- R1: With the default parameters there are 8 channels, each sees the same 32 source lines, and channel n drives exactly one output bit, `irq_out[n]`.
- R2: After reset every enable register reads 0 and every output bit is 0.
- R3: The enable register of channel n sits at byte address 0x10 + 0x40*n. A write stores all 32 bits, and a read returns the last value written, so a saved value can be written back to restore the channel.
- R4: The pending register of channel n sits at byte address 0x20 + 0x40*n. It reads as the bitwise AND of the source lines and that channel's enable register, in the same cycle as the read address.
- R5: A write to a pending register is ignored. The enable register and the outputs of that channel do not change.
- R6: `irq_out[n]` is registered. It is 1 on the clock edge after any source whose enable bit is 1 in channel n is high, stays 1 for as long as such a source stays high, and returns to 0 one edge after none is.
- R7: Writing 0 to a channel's enable register blocks all 32 of its sources at once, and its output drops on the following edge.
- R8: An address that is not one of the mapped registers reads as 0, and a write to it changes nothing. This covers other offsets within a stride, unaligned offsets, and addresses with any bit above the channel index set.
- R9: A write to one channel's enable register leaves the enable registers and outputs of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | 32 | Level-sensitive interrupt sources, active high |
| reg_addr | input | 10 | Byte address of the register access |
| reg_we | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 8 | Registered interrupt output, one bit per channel |

## Verification
The bench goes after channel decoding at the extremes: channel 0, channel 7 and bit 31. A stride or offset error would show up there as a read-back from the wrong channel or a missed output. It writes to pending registers and to near-miss addresses, such as an unaligned byte inside an enable word, a channel index with an extra high bit, and unused offsets. A decoder that is too loose would either corrupt an enable register or return data where it should return 0. It clears one channel while a neighbour stays active, and it holds a source high over many cycles before dropping it. A design that shares enable storage across channels, or that latches an output instead of following the level, would then leave the wrong bit set. Each output is sampled exactly one edge after its cause, which catches both a missing register stage and an extra one.

// File: rtl/irq_fanin_mux.sv
module irq_fanin_mux #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] src_lvl,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] irq_out
);
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int HI_LSB = 6 + CH_W;
  localparam logic [5:0] OFF_EN   = 6'h10;
  localparam logic [5:0] OFF_PEND = 6'h20;

  logic [NUM_CH-1:0][DATA_W-1:0] en_q;
  logic [NUM_CH-1:0][DATA_W-1:0] pend;
  logic [CH_W-1:0] ch_idx;
  logic [5:0]      off;
  logic            hi_clear, ch_ok, hit_en, hit_pend;

  assign ch_idx = reg_addr[6 +: CH_W];
  assign off    = reg_addr[5:0];
  assign ch_ok  = {{(32-CH_W){1'b0}}, ch_idx} < NUM_CH;

  generate
    if (ADDR_W > HI_LSB) begin : g_hi
      assign hi_clear = (reg_addr[ADDR_W-1:HI_LSB] == '0);
    end else begin : g_nohi
      assign hi_clear = 1'b1;
    end
  endgenerate

  assign hit_en   = hi_clear && ch_ok && (off == OFF_EN);
  assign hit_pend = hi_clear && ch_ok && (off == OFF_PEND);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk) begin
        if (!rst_n)
          en_q[c] <= '0;
        else if (reg_we && hit_en && ch_idx == CH_W'(c))
          en_q[c] <= reg_wdata;
      end

      assign pend[c] = src_lvl & en_q[c];

      always_ff @(posedge clk) begin
        if (!rst_n) irq_out[c] <= 1'b0;
        else        irq_out[c] <= |pend[c];
      end

      // R6
      irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[c] |-> $past(|en_q[c]));

      // R7
      irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && hit_en && ch_idx == CH_W'(c) && reg_wdata == '0) |=> ##1 !irq_out[c]);
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    if (hit_en)        reg_rdata = en_q[ch_idx];
    else if (hit_pend) reg_rdata = pend[ch_idx];
  end

  // R3
  en_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && hit_en) |=> en_q[$past(ch_idx)] == $past(reg_wdata));

  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && hit_en) |=> $stable(en_q));

  // R4
  pend_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pend |-> (reg_rdata & ~src_lvl) == '0);

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_en && !hit_pend) |-> reg_rdata == '0);
endmodule

// File: tb/test_irq_fanin_mux.sv
`timescale 1ns/1ps
module test_irq_fanin_mux;
  localparam int NCH = 8;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lvl = '0;
  logic [9:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  irq_out;
  int total = 0, bad = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  irq_fanin_mux i_irq_fanin_mux (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out));

  localparam int NV = 6;
  localparam int          V_CH  [NV] = '{0, 3, 7, 5, 1, 2};
  localparam logic [31:0] V_EN  [NV] = '{32'hFFFF_FFFF, 32'h0000_FFFF, 32'h8000_0000,
                                         32'hA5A5_A5A5, 32'h0000_0000, 32'h1234_5678};
  localparam logic [31:0] V_SRC [NV] = '{32'h0000_0001, 32'hFFFF_0000, 32'h8000_0001,
                                         32'h0F0F_0F0F, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
  localparam logic [31:0] V_PND [NV] = '{32'h0000_0001, 32'h0000_0000, 32'h8000_0000,
                                         32'h0505_0505, 32'h0000_0000, 32'h1234_5678};
  localparam logic        V_IRQ [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

  function automatic logic [9:0] en_a(int n);   return 10'(32'h10 + 32'h40 * n); endfunction
  function automatic logic [9:0] pnd_a(int n);  return 10'(32'h20 + 32'h40 * n); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rdr(logic [9:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    src_lvl = 32'hFFFF_FFFF;
    settle();
    // R2 reset state
    chk("R2 irq", {24'h0, irq_out}, 32'h0);
    for (int c = 0; c < NCH; c++) begin
      rdr(en_a(c), rd); chk("R2 enable", rd, 32'h0);
    end

    // vector table: R3 R4 R6 R7
    for (int i = 0; i < NV; i++) begin
      src_lvl = V_SRC[i];
      wr(en_a(V_CH[i]), V_EN[i]);
      rdr(en_a(V_CH[i]), rd);  chk("R3 readback", rd, V_EN[i]);
      rdr(pnd_a(V_CH[i]), rd); chk("R4 pending", rd, V_PND[i]);
      chk("R6 irq", {31'h0, irq_out[V_CH[i]]}, {31'h0, V_IRQ[i]});
      wr(en_a(V_CH[i]), 32'h0);
      @(negedge clk);
      chk("R7 cleared", {31'h0, irq_out[V_CH[i]]}, 32'h0);
      rdr(pnd_a(V_CH[i]), rd); chk("R7 pending", rd, 32'h0);
    end

    // R6 exact timing and level persistence
    src_lvl = 32'h0;
    wr(en_a(4), 32'h0000_0100);
    settle();
    chk("R6 idle", {31'h0, irq_out[4]}, 32'h0);
    @(negedge clk); src_lvl = 32'h0000_0100;
    #1 chk("R6 not before edge", {31'h0, irq_out[4]}, 32'h0);
    @(negedge clk);
    chk("R6 one edge later", {31'h0, irq_out[4]}, 32'h1);
    repeat (10) @(negedge clk);
    chk("R6 held", {31'h0, irq_out[4]}, 32'h1);
    src_lvl = 32'h0;
    @(negedge clk);
    chk("R6 drop", {31'h0, irq_out[4]}, 32'h0);

    // R5 pending writes ignored
    src_lvl = 32'hFFFF_FFFF;
    wr(pnd_a(4), 32'hFFFF_FFFF);
    wr(pnd_a(6), 32'hFFFF_FFFF);
    rdr(en_a(4), rd); chk("R5 enable kept", rd, 32'h0000_0100);
    rdr(en_a(6), rd); chk("R5 enable untouched", rd, 32'h0);
    rdr(pnd_a(6), rd); chk("R5 pending", rd, 32'h0);
    chk("R5 irq6", {31'h0, irq_out[6]}, 32'h0);
    wr(en_a(4), 32'h0);

    // R8 unmapped addresses
    wr(en_a(0), 32'hFFFF_FFFF);
    wr(10'h210, 32'h0);
    wr(10'h012, 32'h0);
    wr(10'h000, 32'h0);
    wr(10'h014, 32'h0);
    rdr(en_a(0), rd); chk("R8 write ignored", rd, 32'hFFFF_FFFF);
    rdr(10'h210, rd); chk("R8 high bit", rd, 32'h0);
    rdr(10'h011, rd); chk("R8 unaligned", rd, 32'h0);
    rdr(10'h030, rd); chk("R8 other offset", rd, 32'h0);
    rdr(10'h000, rd); chk("R8 offset zero", rd, 32'h0);
    rdr(10'h3E0, rd); chk("R8 top", rd, 32'h0);
    wr(en_a(0), 32'h0);

    // R9 independence
    src_lvl = 32'h0000_0002;
    wr(en_a(6), 32'h0000_0002);
    wr(en_a(2), 32'h0000_0002);
    settle();
    chk("R9 both on", {24'h0, irq_out}, 32'h0000_0044);
    wr(en_a(6), 32'h0);
    @(negedge clk);
    chk("R9 only ch2", {24'h0, irq_out}, 32'h0000_0004);
    rdr(en_a(2), rd); chk("R9 ch2 kept", rd, 32'h0000_0002);
    wr(en_a(2), 32'h0);

    // R1 every channel drives its own bit
    src_lvl = 32'hFFFF_FFFF;
    for (int c = 0; c < NCH; c++) wr(en_a(c), 32'h1 << c);
    settle();
    chk("R1 all outputs", {24'h0, irq_out}, 32'h0000_00FF);
    for (int c = 0; c < NCH; c++) begin
      rdr(pnd_a(c), rd); chk("R1 per channel", rd, 32'h1 << c);
    end
    src_lvl = 32'hFFFF_FFFE;
    settle();
    chk("R1 bit0 only ch0", {24'h0, irq_out}, 32'h0000_00FE);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule